// File: doc/BRIEF.md
# Byte-lane vector condition flag generator

This block derives condition flags from the result of a 16-lane byte vector operation and keeps them in a small register file of four 32-bit condition words. Each lane contributes a sign flag and a zero flag. The sign flag depends on the kind of operation that produced the result: signed arithmetic, unsigned arithmetic or wide add, bitwise or move, or clip-to-range. The zero flag always tests the stored byte. A flag-writing instruction replaces one selected word, or leaves the file alone, according to three opcode bits.

The arithmetic datapath is outside this block. It supplies a 9-bit lane result (the unclamped value) and, for clip, the three source bytes of each lane. A separate load port writes any one condition word directly. The whole file is presented as one 128-bit value, so the next instruction can read the flags one clock after a write.

Top module: `vec_cond_flags`

## Requirements
- R1: After reset all 128 bits of `cond_q` are zero.
- R2: When `wr_en` is 0, or when `op_bits[2]` is 1, an instruction leaves every condition word unchanged.
- R3: When `wr_en` is 1 and `op_bits[2]` is 0, only word `op_bits[1:0]` (bits 32*w+31 to 32*w of `cond_q`) is replaced. The other three words keep their values.
- R4: With `op_class` = 2'b00 (signed), the sign flag of lane l (word bit l) equals bit 7 of that lane's result.
- R5: With `op_class` = 2'b01 (unsigned or 8/9-bit add), the sign flag of lane l equals bit 8 of the unclamped lane result.
- R6: With `op_class` = 2'b10 (bitwise or register move), all 16 sign flags are written as 0.
- R7: With `op_class` = 2'b11 (clip), the sign flag of lane l is 0 exactly when lo < val < hi as unsigned bytes, where val is `src_a`, lo is `src_b` and hi is `src_c` for that lane. Otherwise it is 1, which includes an inverted range.
- R8: For every class, the zero flag of lane l (word bit 16+l) is 1 exactly when bits 7:0 of that lane's result are all zero.
- R9: A write is visible on `cond_q` on the clock edge that samples the strobe, so it is seen by the next cycle's consumer.
- R10: When `ld_en` is 1, word `ld_sel` takes `ld_data` at the next edge. If an instruction targets the same word in that cycle, the load wins. An instruction aimed at a different word still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Flag-writing instruction strobe |
| op_bits | input | 3 | Bit 2 suppresses the write; bits 1:0 select the word |
| op_class | input | 2 | Sign-flag rule: 00 signed, 01 unsigned/wide add, 10 logic/move, 11 clip |
| lane_res | input | 144 | 9-bit unclamped result per lane, lane l at bits 9l+8:9l |
| src_a | input | 128 | Clip value per lane, byte l at bits 8l+7:8l |
| src_b | input | 128 | Clip lower bound per lane |
| src_c | input | 128 | Clip upper bound per lane |
| ld_en | input | 1 | Direct load strobe |
| ld_sel | input | 2 | Word index for the direct load |
| ld_data | input | 32 | Value for the direct load |
| cond_q | output | 128 | All four condition words, word w at bits 32w+31:32w |

## Verification
The clip rule is swept over every ordering of three values. This is done once with small values and once with values spread across the full byte range, so a design that compares signed bytes, or uses ≤ in place of <, marks the wrong lanes. The signed and unsigned classes are driven with results whose bit 7 and bit 8 differ and whose low byte is zero while bit 8 is set. A design that picks the wrong bit, or tests nine bits for zero, then fails. Every word index is written in turn against a file of distinct values, with bit 2 also set, which catches a wrong or leaking word select. A load and an instruction are also sent to the same word and to different words in one cycle, which catches an inverted priority or a dropped write.

// File: rtl/vec_cond_flags.sv
module vec_cond_flags #(
  parameter int LANES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           op_bits,
  input  logic [1:0]           op_class,
  input  logic [LANES*9-1:0]   lane_res,
  input  logic [LANES*8-1:0]   src_a,
  input  logic [LANES*8-1:0]   src_b,
  input  logic [LANES*8-1:0]   src_c,
  input  logic                 ld_en,
  input  logic [1:0]           ld_sel,
  input  logic [2*LANES-1:0]   ld_data,
  output logic [8*LANES-1:0]   cond_q
);
  localparam int WW = 2 * LANES;
  localparam int NW = 4;

  logic [LANES-1:0] sgn, zf;
  logic [WW-1:0]    word_q [NW];
  logic             ins_go;

  assign ins_go = wr_en && !op_bits[2];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [8:0] r;
    logic [7:0] a, b, c;
    assign r = lane_res[9*l +: 9];
    assign a = src_a[8*l +: 8];
    assign b = src_b[8*l +: 8];
    assign c = src_c[8*l +: 8];
    assign zf[l] = (r[7:0] == 8'd0);
    always_comb begin
      case (op_class)
        2'b00:   sgn[l] = r[7];
        2'b01:   sgn[l] = r[8];
        2'b10:   sgn[l] = 1'b0;
        default: sgn[l] = !((b < a) && (a < c));
      endcase
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q[w] <= '0;
      else if (ld_en && ld_sel == w[1:0])
        word_q[w] <= ld_data;
      else if (ins_go && op_bits[1:0] == w[1:0])
        word_q[w] <= {zf, sgn};
    end
    assign cond_q[WW*w +: WW] = word_q[w];

    assert_untouched_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && !op_bits[2] && op_bits[1:0] == w[1:0]) && !(ld_en && ld_sel == w[1:0]))
        |=> $stable(cond_q[WW*w +: WW]));

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_sel == w[1:0]) |=> cond_q[WW*w +: WW] == $past(ld_data));

    assert_logic_sign_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !op_bits[2] && op_bits[1:0] == w[1:0] && op_class == 2'b10 &&
       !(ld_en && ld_sel == w[1:0]))
        |=> cond_q[WW*w +: LANES] == '0);
  end

  assert_suppressed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && !op_bits[2]) && !ld_en) |=> $stable(cond_q));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> cond_q == '0);

endmodule

// File: tb/vec_cond_flags_tb_top.sv
module vec_cond_flags_tb_top;
  localparam int L = 16;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, ld_en = 0;
  logic [2:0] op_bits = 0;
  logic [1:0] op_class = 0, ld_sel = 0;
  logic [L*9-1:0] lane_res = '0;
  logic [L*8-1:0] src_a = '0, src_b = '0, src_c = '0;
  logic [2*L-1:0] ld_data = '0;
  logic [8*L-1:0] cond_q;
  logic [31:0] model [4];
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  vec_cond_flags #(.LANES(L)) dut_i (.*);

  function automatic logic [31:0] exp_word(input logic [1:0] cls);
    logic [31:0] v;
    for (int l = 0; l < L; l++) begin
      logic [8:0] r;
      logic [7:0] a, b, c;
      r = lane_res[9*l +: 9];
      a = src_a[8*l +: 8]; b = src_b[8*l +: 8]; c = src_c[8*l +: 8];
      v[16+l] = (r % 256) == 0;
      case (cls)
        2'b00: v[l] = (r % 256) >= 128;
        2'b01: v[l] = r >= 256;
        2'b10: v[l] = 1'b0;
        default: v[l] = !((int'(b) < int'(a)) && (int'(a) < int'(c)));
      endcase
    end
    return v;
  endfunction

  task automatic check(input string tag);
    logic [127:0] e;
    e = {model[3], model[2], model[1], model[0]};
    checks++;
    if (cond_q !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, cond_q, e);
    end
  endtask

  task automatic step(input bit we, input [2:0] op, input [1:0] cls,
                      input bit le, input [1:0] ls, input [31:0] ld, input string tag);
    logic [31:0] nw;
    @(negedge clk);
    wr_en = we; op_bits = op; op_class = cls;
    ld_en = le; ld_sel = ls; ld_data = ld;
    nw = exp_word(cls);
    @(posedge clk);
    if (we && !op[2] && !(le && ls == op[1:0])) model[op[1:0]] = nw;
    if (le) model[ls] = ld;
    @(negedge clk);
    wr_en = 0; ld_en = 0;
    check(tag);
  endtask

  initial begin
    #(20*200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++) model[w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset");
    rst_n = 1;

    // R9/R4/R8: signed class, patterns with distinct bit7/bit8
    for (int p = 0; p < 24; p++) begin
      for (int l = 0; l < L; l++) lane_res[9*l +: 9] = 9'((p*37 + l*29 + (l == p % L ? 0 : 1)) % 512);
      lane_res[8:0] = 9'h100;
      step(1, 3'(p % 4), 2'b00, 0, 0, 0, "R4 R8 R9 signed");
    end
    // R5/R8 unsigned
    for (int p = 0; p < 24; p++) begin
      for (int l = 0; l < L; l++) lane_res[9*l +: 9] = 9'((p*53 + l*71) % 512);
      lane_res[9*3 +: 9] = 9'h180;
      lane_res[9*4 +: 9] = 9'h07f;
      step(1, 3'(p % 4), 2'b01, 0, 0, 0, "R5 R8 unsigned");
    end
    // R6 logic
    for (int p = 0; p < 8; p++) begin
      for (int l = 0; l < L; l++) lane_res[9*l +: 9] = 9'((p*97 + l*131) % 512);
      lane_res[9*(p%L) +: 9] = 9'h000;
      step(1, 3'(p % 4), 2'b10, 0, 0, 0, "R6 R8 logic");
    end
    // R7 clip: every ordering of three values, small and wide scales
    for (int s = 0; s < 2; s++)
      for (int bt = 0; bt < 4; bt++) begin
        for (int l = 0; l < L; l++) begin
          int cix, k;
          cix = bt*16 + l;
          k = (s == 0) ? 1 : 85;
          src_a[8*l +: 8] = 8'((cix % 4) * k);
          src_b[8*l +: 8] = 8'(((cix / 4) % 4) * k);
          src_c[8*l +: 8] = 8'(((cix / 16) % 4) * k);
          lane_res[9*l +: 9] = 9'(l * 7);
        end
        step(1, 3'(bt), 2'b11, 0, 0, 0, "R7 clip");
      end
    // R2: distinct load pattern, then suppressed writes
    for (int w = 0; w < 4; w++) step(0, 0, 0, 1, 2'(w), 32'h1111_0000 * (w+1) + 32'h0f0f, "R10 load");
    for (int l = 0; l < L; l++) lane_res[9*l +: 9] = 9'h0ff;
    for (int w = 0; w < 4; w++) step(1, 3'(4 + w), 2'b00, 0, 0, 0, "R2 op bit2 set");
    for (int w = 0; w < 4; w++) step(0, 3'(w), 2'b01, 0, 0, 0, "R2 strobe low");
    // R3 word select against distinct contents
    for (int w = 0; w < 4; w++) step(1, 3'(w), 2'b00, 0, 0, 0, "R3 select");
    // R10 priority
    step(1, 3'd2, 2'b00, 1, 2'd2, 32'hdead_beef, "R10 same word load wins");
    for (int l = 0; l < L; l++) lane_res[9*l +: 9] = 9'h000;
    step(1, 3'd1, 2'b10, 1, 2'd3, 32'h1234_5678, "R10 different word both");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule